// File: doc/BRIEF.md
# Programmable Transposed-Form FIR Filter

This block is a ten-tap finite impulse response filter whose coefficients can be rewritten while it runs. Samples arrive on a stream that is qualified by a valid strobe. Each accepted sample is scaled by every coefficient at once. The scaled values are folded into a chain of registered partial sums in transposed form. As a result, the only adder that follows a register on the output path is a single two-input adder.

No tap holds a general multiplier. A single shared stage computes the odd multiples 1, 3, 5, ... 15 of the current sample. Each tap splits its coefficient magnitude into 4-bit groups. For each group it picks one of the shared multiples, shifts it into place and adds the results. A zero group contributes nothing. The tap then negates the sum when the coefficient sign bit is set.

Coefficients are loaded through a write port that carries a tap index and a value. A write changes only the products that later samples form. Partial sums already in the chain keep the values they were built with.

Top module: `fir_tdf_top`

## Requirements
- R1: For the accepted samples x(n), x(n-1), ... (counting only cycles with `in_valid` high), the output is y(n) = sum over k = 0..9 of c_k·x(n-k). Here c_k is the coefficient held by tap k when sample x(n-k) was accepted, and samples before reset count as zero.
- R2: `in_data` is a 17-bit two's complement value. A coefficient is 17 bits in sign-magnitude form: bit 16 is the sign (1 = negative) and bits 15:0 are the magnitude. A coefficient with sign 1 and magnitude 0 acts as zero.
- R3: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise. `out_data` carries that sample's result in the same cycle.
- R4: In cycles with `in_valid` low, the chain does not advance and `out_data` holds its last value.
- R5: With `cw_en` high, `cw_val` is written to tap `cw_idx`, where tap k weights the sample k positions back. A write in a cycle with no sample applies from the next sample. A write in the same cycle as a sample applies from the sample after it. Partial sums already in the chain are unaffected.
- R6: A write with `cw_idx` of 10 or more changes no coefficient.
- R7: A synchronous reset clears every coefficient, every partial sum, `out_data` and `out_valid` to zero.
- R8: The 37-bit output holds the sum of ten full-scale products exactly. One such case is ten copies of -65536 × -65535 = 42949017600.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 17 | Sample, two's complement |
| cw_en | input | 1 | Coefficient write enable |
| cw_idx | input | 4 | Tap index of the write |
| cw_val | input | 17 | Coefficient, sign-magnitude |
| out_valid | output | 1 | Result strobe, one cycle after the sample |
| out_data | output | 37 | Filtered result, two's complement |

## Verification
A single unit sample followed by zeros reads out the coefficients one per output, in tap order. This pattern exposes a wrong index mapping, a broken select group or a missing sign. Random samples with irregular idle gaps, run against random coefficients that include zeros and negative values, separate a chain that advances on every clock from one that advances only on valid samples. Coefficient writes placed both between samples and in the same cycle as a sample distinguish correct write timing from disturbance of partial sums already in flight. Full-scale negative operands on every tap reveal any shortfall in accumulator width.

// File: rtl/fir_tdf_pkg.sv
package fir_tdf_pkg;
   localparam int DEF_TAPS   = 10;
   localparam int DEF_DATA_W = 17;
   localparam int DEF_COEF_W = 17;
   localparam int DEF_NIB_W  = 4;

   // position of the lowest set bit of a group (0 when the group is zero)
   function automatic int low_one(input logic [31:0] v, input int w);
      int pos;
      pos = 0;
      for (int i = w - 1; i >= 0; i--) begin
         if (v[i]) pos = i;
      end
      return pos;
   endfunction
endpackage

// File: rtl/fir_odd_multiples.sv
module fir_odd_multiples #(
   parameter int DATA_W = 17,
   parameter int NIB_W  = 4,
   localparam int ALPHA = 2 ** (NIB_W - 1),
   localparam int PRE_W = DATA_W + NIB_W
) (
   input  logic [DATA_W-1:0]            x,
   output logic [ALPHA-1:0][PRE_W-1:0]  mult
);
   logic signed [PRE_W-1:0] xe;
   assign xe = PRE_W'($signed(x));

   for (genvar a = 0; a < ALPHA; a++) begin : g_odd
      localparam logic signed [PRE_W-1:0] K = PRE_W'(2 * a + 1);
      assign mult[a] = xe * K;
   end
endmodule

// File: rtl/fir_nib_select.sv
module fir_nib_select #(
   parameter int DATA_W = 17,
   parameter int NIB_W  = 4,
   localparam int ALPHA = 2 ** (NIB_W - 1),
   localparam int PRE_W = DATA_W + NIB_W,
   localparam int SEL_W = PRE_W + NIB_W - 1,
   localparam int SH_W  = (NIB_W > 2) ? $clog2(NIB_W) : 1
) (
   input  logic [NIB_W-1:0]            nib,
   input  logic [ALPHA-1:0][PRE_W-1:0] mult,
   output logic [SEL_W-1:0]            part
);
   import fir_tdf_pkg::*;

   logic [SH_W-1:0]  sh;
   logic [NIB_W-1:0] odd;
   logic [NIB_W-2:0] idx;

   always_comb begin
      sh   = SH_W'(low_one(32'(nib), NIB_W));
      odd  = nib >> sh;
      idx  = odd[NIB_W-1:1];
      part = '0;
      if (nib != '0) part = SEL_W'($signed(mult[idx])) <<< sh;
   end
endmodule

// File: rtl/fir_tap_sna.sv
module fir_tap_sna #(
   parameter int DATA_W = 17,
   parameter int COEF_W = 17,
   parameter int NIB_W  = 4,
   localparam int ALPHA  = 2 ** (NIB_W - 1),
   localparam int PRE_W  = DATA_W + NIB_W,
   localparam int SEL_W  = PRE_W + NIB_W - 1,
   localparam int MAG_W  = COEF_W - 1,
   localparam int NIBS   = MAG_W / NIB_W,
   localparam int PROD_W = DATA_W + MAG_W
) (
   input  logic [COEF_W-1:0]           coef,
   input  logic [ALPHA-1:0][PRE_W-1:0] mult,
   output logic [PROD_W-1:0]           prod
);
   logic [NIBS-1:0][SEL_W-1:0] parts;
   logic signed [PROD_W-1:0]   acc;

   for (genvar n = 0; n < NIBS; n++) begin : g_grp
      fir_nib_select #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_sel (
         .nib  (coef[n*NIB_W +: NIB_W]),
         .mult (mult),
         .part (parts[n])
      );
   end

   always_comb begin
      acc = '0;
      for (int n = 0; n < NIBS; n++) begin
         acc = acc + (PROD_W'($signed(parts[n])) <<< (n * NIB_W));
      end
      prod = coef[COEF_W-1] ? PROD_W'(-acc) : PROD_W'(acc);
   end
endmodule

// File: rtl/fir_tdf_top.sv
module fir_tdf_top #(
   parameter int TAPS   = fir_tdf_pkg::DEF_TAPS,
   parameter int DATA_W = fir_tdf_pkg::DEF_DATA_W,
   parameter int COEF_W = fir_tdf_pkg::DEF_COEF_W,
   parameter int NIB_W  = fir_tdf_pkg::DEF_NIB_W,
   localparam int IDX_W  = $clog2(TAPS),
   localparam int PROD_W = DATA_W + COEF_W - 1,
   localparam int ACC_W  = PROD_W + $clog2(TAPS),
   localparam int ALPHA  = 2 ** (NIB_W - 1),
   localparam int PRE_W  = DATA_W + NIB_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              cw_en,
   input  logic [IDX_W-1:0]  cw_idx,
   input  logic [COEF_W-1:0] cw_val,
   output logic              out_valid,
   output logic [ACC_W-1:0]  out_data
);
   if (TAPS < 2) begin : g_bad_taps
      $error("fir_tdf_top: TAPS must be at least 2");
   end
   if (NIB_W < 2) begin : g_bad_nib
      $error("fir_tdf_top: NIB_W must be at least 2");
   end
   if ((COEF_W - 1) % NIB_W != 0) begin : g_bad_split
      $error("fir_tdf_top: coefficient magnitude must split into whole groups");
   end

   logic [TAPS-1:0][COEF_W-1:0] coef_q;
   logic [ALPHA-1:0][PRE_W-1:0] mult;
   logic [TAPS-1:0][PROD_W-1:0] prod;
   logic [TAPS-1:0][ACC_W-1:0]  sum;
   logic [TAPS-1:1][ACC_W-1:0]  zreg;
   logic                        wr_hit;

   assign wr_hit = cw_en && ({1'b0, cw_idx} < (IDX_W + 1)'(TAPS));

   always_ff @(posedge clk) begin
      if (rst) coef_q <= '0;
      else if (wr_hit) coef_q[cw_idx] <= cw_val;
   end

   fir_odd_multiples #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_pre (
      .x    (in_data),
      .mult (mult)
   );

   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      fir_tap_sna #(.DATA_W(DATA_W), .COEF_W(COEF_W), .NIB_W(NIB_W)) u_sna (
         .coef (coef_q[k]),
         .mult (mult),
         .prod (prod[k])
      );
      if (k == TAPS - 1) begin : g_last
         assign sum[k] = ACC_W'($signed(prod[k]));
      end else begin : g_mid
         assign sum[k] = ACC_W'($signed(prod[k])) + zreg[k+1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         zreg      <= '0;
         out_data  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            zreg     <= sum[TAPS-1:1];
            out_data <= sum[0];
         end
      end
   end
endmodule

// File: rtl/fir_tdf_chk.sv
module fir_tdf_chk #(
   parameter int TAPS   = 10,
   parameter int COEF_W = 17,
   parameter int IDX_W  = 4,
   parameter int PROD_W = 33,
   parameter int ACC_W  = 37
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        in_valid,
   input logic                        cw_en,
   input logic [IDX_W-1:0]            cw_idx,
   input logic                        out_valid,
   input logic [ACC_W-1:0]            out_data,
   input logic [TAPS-1:0][COEF_W-1:0] coef_q,
   input logic [TAPS-1:0][PROD_W-1:0] prod
);
   logic past_rst;
   always_ff @(posedge clk) past_rst <= rst;

   // R7
   always_ff @(posedge clk) begin
      if (past_rst) begin
         reset_clear_chk: assert (!out_valid && out_data == '0 && coef_q == '0)
            else $error("R7 reset did not clear state");
      end
   end

   // R3
   valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R3
   valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_data));

   // R6
   coef_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !(cw_en && {1'b0, cw_idx} < (IDX_W + 1)'(TAPS)) |=> $stable(coef_q));

   for (genvar k = 0; k < TAPS; k++) begin : g_zero
      // R2
      zero_mag_chk: assert property (@(posedge clk) disable iff (rst)
         coef_q[k][COEF_W-2:0] == '0 |-> prod[k] == '0);
   end
endmodule

bind fir_tdf_top fir_tdf_chk #(
   .TAPS(TAPS), .COEF_W(COEF_W), .IDX_W(IDX_W), .PROD_W(PROD_W), .ACC_W(ACC_W)
) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .cw_en(cw_en), .cw_idx(cw_idx),
   .out_valid(out_valid), .out_data(out_data), .coef_q(coef_q), .prod(prod)
);

// File: tb/fir_tdf_top_bench.sv
module fir_tdf_top_bench;
   localparam int TAPS = 10;
   localparam int DW = 17;
   localparam int CW = 17;
   localparam int AW = 37;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          cw_en = 1'b0;
   logic [3:0]    cw_idx = '0;
   logic [CW-1:0] cw_val = '0;
   logic          out_valid;
   logic [AW-1:0] out_data;

   always #4 clk = ~clk;

   fir_tdf_top u_fir_tdf_top (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .cw_en(cw_en), .cw_idx(cw_idx), .cw_val(cw_val),
      .out_valid(out_valid), .out_data(out_data)
   );

   typedef longint cvec_t [TAPS];
   cvec_t  hs[$];
   longint hx[$];
   cvec_t  mc;
   longint exp_y;
   logic   exp_v;
   int     checks = 0;
   int     errors = 0;
   bit     done = 0;

   function automatic longint cval(input logic [CW-1:0] c);
      return c[CW-1] ? -longint'(c[CW-2:0]) : longint'(c[CW-2:0]);
   endfunction

   task automatic compare(input string tag);
      longint got;
      got = longint'($signed(out_data));
      checks++;
      if (out_valid !== exp_v || got != exp_y) begin
         errors++;
         $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
                  tag, out_valid, got, exp_v, exp_y);
      end
   endtask

   // entered and left at a falling edge
   task automatic step(input bit v, input longint x, input bit we,
                       input int idx, input logic [CW-1:0] val, input string tag);
      in_valid = v;
      in_data  = DW'(x);
      cw_en    = we;
      cw_idx   = 4'(idx);
      cw_val   = val;
      @(posedge clk);
      if (v) begin
         longint y;
         hx.push_front(x);
         hs.push_front(mc);
         if (hx.size() > TAPS) begin
            void'(hx.pop_back());
            void'(hs.pop_back());
         end
         y = 0;
         for (int k = 0; k < hx.size(); k++) y += hx[k] * hs[k][k];
         exp_y = y;
      end
      exp_v = v;
      if (we && idx < TAPS) mc[idx] = cval(val);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      in_valid = 1'b0;
      cw_en = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      hx.delete();
      hs.delete();
      for (int k = 0; k < TAPS; k++) mc[k] = 0;
      exp_y = 0;
      exp_v = 0;
      compare("R7 reset state");
   endtask

   task automatic wr(input int idx, input logic [CW-1:0] val, input string tag);
      step(1'b0, 0, 1'b1, idx, val, tag);
   endtask

   task automatic impulse(input string tag);
      step(1'b1, 1, 1'b0, 0, '0, tag);
      for (int i = 0; i < TAPS + 1; i++) step(1'b1, 0, 1'b0, 0, '0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();

      // R1 R5 tap order: impulse reads coefficients back in index order
      for (int k = 0; k < TAPS; k++) wr(k, CW'(k + 1), "R5 write");
      impulse("R1 impulse");

      // R2 negative and negative-zero coefficients
      wr(3, {1'b1, 16'd0}, "R2 write");
      wr(4, {1'b1, 16'd5}, "R2 write");
      wr(7, {1'b1, 16'hFFFF}, "R2 write");
      impulse("R2 signed impulse");
      step(1'b1, -3, 1'b0, 0, '0, "R2 negative sample");
      step(1'b1, 65535, 1'b0, 0, '0, "R2 max sample");

      // R6 out-of-range indices change nothing
      for (int i = 10; i < 16; i++) wr(i, {1'b0, 16'h1234}, "R6 ignored write");
      impulse("R6 impulse after ignored writes");

      // R5 write in the same cycle as a sample, with partial sums in flight
      for (int i = 0; i < 4; i++) step(1'b1, 100 * (i + 1), 1'b0, 0, '0, "R5 fill");
      step(1'b1, 7, 1'b1, 0, {1'b0, 16'd50}, "R5 same-cycle write");
      step(1'b1, 9, 1'b1, 2, {1'b1, 16'd77}, "R5 same-cycle write");
      step(1'b1, 11, 1'b0, 0, '0, "R5 after write");
      wr(1, {1'b0, 16'd300}, "R5 idle write");
      step(1'b1, -5, 1'b0, 0, '0, "R5 next sample");

      // R1 R4 R5 random coefficients, samples, gaps and writes
      for (int k = 0; k < TAPS; k++) begin
         logic [15:0] m;
         m = ($urandom % 4 == 0) ? 16'd0 : 16'($urandom);
         wr(k, {1'($urandom), m}, "R1 random coef");
      end
      for (int i = 0; i < 300; i++) begin
         bit v;
         bit we;
         int idx;
         logic [15:0] m;
         v   = ($urandom % 3) != 0;
         we  = ($urandom % 8) == 0;
         idx = $urandom % 16;
         m   = ($urandom % 4 == 0) ? 16'd0 : 16'($urandom);
         step(v, longint'($signed(DW'($urandom))), we, idx, {1'($urandom), m},
              v ? "R1 random stream" : "R4 idle cycle");
      end

      // R8 full-scale products on every tap
      for (int k = 0; k < TAPS; k++) wr(k, {1'b1, 16'hFFFF}, "R8 write");
      for (int i = 0; i < TAPS + 2; i++) step(1'b1, -65536, 1'b0, 0, '0, "R8 full scale");
      for (int k = 0; k < TAPS; k++) wr(k, {1'b0, 16'hFFFF}, "R8 write");
      for (int i = 0; i < TAPS + 2; i++) step(1'b1, -65536, 1'b0, 0, '0, "R8 full scale");

      // R7 reset clears coefficients and chain
      do_reset();
      impulse("R7 impulse after reset");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule